// File: doc/BRIEF.md
# Two-Phase Non-Overlapping Clock Generator

This block turns one fast clock into two slower phase strobes whose high windows never coincide. A small free-running step counter advances once per enabled clock. A one-hot decoder expands its state into one line per state, and the decoded lines are registered before they leave the block. Two of those registered lines serve as the phases. The phase lines are two states apart, so an idle state always separates a phase from the next one. Each phase is high for one input-clock cycle in every four. A pair of cascaded latches driven by the two phases therefore never has both latches transparent at once.

The reset is synchronous and active low. The enable input freezes the counter and holds every output low. When enable returns, the rotation resumes from the state where it stopped. The registered decode lines are also brought out, so that downstream logic can use the idle slots.

Top module: `ncg_two_phase_gen`

## Requirements
- R1: While rst_n is sampled low at a rising edge, the next cycle shows dec_lines = 0, phi1 = 0 and phi2 = 0, and the step counter returns to state 0.
- R2: When rst_n is first sampled high with en high, phi1 is high in the following cycle, because decode line 0 is registered first.
- R3: dec_lines holds at most one high bit. Under continuous enable, the high bit walks upward by one position per cycle: bit 0, bit 1, bit 2, bit 3, then back to bit 0. Bit k stands for counter state k.
- R4: phi1 always equals dec_lines bit 0 and phi2 always equals dec_lines bit 2.
- R5: phi1 and phi2 are never high in the same cycle.
- R6: In the cycle after either phase is high, both phases are low (an idle gap of at least one full cycle).
- R7: Under continuous enable, phi1 and phi2 are each high in exactly one cycle out of every four.
- R8: A rising edge that samples en low holds the counter and drives dec_lines, phi1 and phi2 to 0 in the next cycle. When en is high again, the rotation continues from the held state.
- R9: A low rst_n takes priority over en being high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Advance enable; low freezes the counter and silences the outputs |
| phi1 | output | 1 | First phase strobe (registered decode line 0) |
| phi2 | output | 1 | Second phase strobe (registered decode line 2) |
| dec_lines | output | 4 | Registered one-hot decode of the counter, bit k for state k |

## Verification
The assertions assume only that rst_n and en are synchronous to clk and are stable around its rising edge; they make no assumption about how often en toggles. The bench changes both inputs only on the falling edge. It sweeps all 256 eight-cycle enable patterns, each starting after a one-cycle reset, so every place where a pause can fall in the rotation is covered. A long continuous-enable run and a reset asserted while en is high are also applied.

// File: rtl/ncg_pkg.sv
// Package: shared sizing for the two-phase generator.
// Assumes the counter width stays small, since one decode line is built per state.
package ncg_pkg;
    localparam int DEFAULT_CNT_W = 2;

    // Number of decode lines for a given counter width.
    function automatic int lines_for(input int cnt_w);
        return 1 << cnt_w;
    endfunction
endpackage

// File: rtl/ncg_step_counter.sv
// Module: free-running wrap-around state counter.
// Advances by one on each rising edge with en high and holds while en is low.
// Assumes rst_n is synchronous to clk.
module ncg_step_counter #(
    parameter int CNT_W = ncg_pkg::DEFAULT_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] count_q
);
    // Purpose: count states, reset to 0, freeze when disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (en)
            count_q <= count_q + CNT_W'(1);
    end
endmodule

// File: rtl/ncg_line_decoder.sv
// Module: combinational one-hot decode of the counter state.
// Every line is forced low while en is low, so the registered copy goes idle.
// Assumes NUM_LINES equals 2**CNT_W.
module ncg_line_decoder #(
    parameter int CNT_W     = ncg_pkg::DEFAULT_CNT_W,
    parameter int NUM_LINES = ncg_pkg::lines_for(CNT_W)
) (
    input  logic                 en,
    input  logic [CNT_W-1:0]     count_q,
    output logic [NUM_LINES-1:0] lines
);
    // Purpose: build one comparator per state.
    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        assign lines[k] = en && (count_q == CNT_W'(k));
    end
endmodule

// File: rtl/ncg_phase_regs.sv
// Module: output register stage for the decode lines and the two phases.
// The phases have their own flops, so no combinational path reaches an output.
// Assumes PHI1_IDX and PHI2_IDX are distinct and non-adjacent in the ring.
module ncg_phase_regs #(
    parameter int NUM_LINES = 4,
    parameter int PHI1_IDX  = 0,
    parameter int PHI2_IDX  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] lines,
    output logic [NUM_LINES-1:0] dec_q,
    output logic                 phi1_q,
    output logic                 phi2_q
);
    // Purpose: capture the decode lines and the phase taps, clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q  <= '0;
            phi1_q <= 1'b0;
            phi2_q <= 1'b0;
        end else begin
            dec_q  <= lines;
            phi1_q <= lines[PHI1_IDX];
            phi2_q <= lines[PHI2_IDX];
        end
    end
endmodule

// File: rtl/ncg_two_phase_gen.sv
// Module: top of the two-phase non-overlapping strobe generator.
// A counter feeds a one-hot decoder, and the registered lines half a ring apart
// become phi1 and phi2.
// Assumes rst_n and en are synchronous to clk.
module ncg_two_phase_gen #(
    parameter int CNT_W = ncg_pkg::DEFAULT_CNT_W
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  en,
    output logic                                  phi1,
    output logic                                  phi2,
    output logic [ncg_pkg::lines_for(CNT_W)-1:0]  dec_lines
);
    localparam int NUM_LINES = ncg_pkg::lines_for(CNT_W);
    localparam int PHI1_IDX  = 0;
    localparam int PHI2_IDX  = NUM_LINES / 2;

    logic [CNT_W-1:0]     count_q;
    logic [NUM_LINES-1:0] lines;

    ncg_step_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .count_q (count_q)
    );

    ncg_line_decoder #(.CNT_W(CNT_W), .NUM_LINES(NUM_LINES)) u_dec (
        .en      (en),
        .count_q (count_q),
        .lines   (lines)
    );

    ncg_phase_regs #(
        .NUM_LINES (NUM_LINES),
        .PHI1_IDX  (PHI1_IDX),
        .PHI2_IDX  (PHI2_IDX)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .lines  (lines),
        .dec_q  (dec_lines),
        .phi1_q (phi1),
        .phi2_q (phi2)
    );
endmodule

// File: rtl/ncg_two_phase_chk.sv
// Module: assertion checker for the two-phase generator, attached by bind.
// Assumes inputs are synchronous to clk.
module ncg_two_phase_chk #(
    parameter int NUM_LINES = 4,
    parameter int PHI1_IDX  = 0,
    parameter int PHI2_IDX  = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 en,
    input logic                 phi1,
    input logic                 phi2,
    input logic [NUM_LINES-1:0] dec_lines
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (dec_lines == '0 && !phi1 && !phi2));

    assert_first_phi1_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n) && en) |=> phi1);

    assert_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dec_lines));

    assert_rotate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && dec_lines != '0) |=>
        (dec_lines == {$past(dec_lines[NUM_LINES-2:0]), $past(dec_lines[NUM_LINES-1])}));

    assert_phase_taps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (phi1 == dec_lines[PHI1_IDX]) && (phi2 == dec_lines[PHI2_IDX]));

    assert_no_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(phi1 && phi2));

    assert_idle_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phi1 || phi2) |=> !(phi1 || phi2));

    assert_disable_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (dec_lines == '0 && !phi1 && !phi2));
endmodule

bind ncg_two_phase_gen ncg_two_phase_chk #(
    .NUM_LINES (NUM_LINES),
    .PHI1_IDX  (PHI1_IDX),
    .PHI2_IDX  (PHI2_IDX)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .phi1      (phi1),
    .phi2      (phi2),
    .dec_lines (dec_lines)
);

// File: tb/ncg_two_phase_gen_tb_top.sv
`timescale 1ns/1ps
// Bench: reference model of the rotation, exhaustive 8-cycle enable sweeps.
module ncg_two_phase_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       phi1, phi2;
    logic [3:0] dec_lines;

    int n_chk = 0;
    int n_bad = 0;
    int model_state = 0;
    logic [3:0] exp_lines = '0;
    logic prev_phase = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ncg_two_phase_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .phi1      (phi1),
        .phi2      (phi2),
        .dec_lines (dec_lines)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Apply inputs for one edge, update the model, compare at the falling edge.
    task automatic step(input logic r, input logic e, input string req);
        rst_n = r;
        en = e;
        @(posedge clk);
        if (!r) begin
            model_state = 0;
            exp_lines = '0;
        end else if (e) begin
            exp_lines = 4'(1 << model_state);
            model_state = (model_state + 1) % 4;
        end else begin
            exp_lines = '0;
        end
        @(negedge clk);
        chk(req, 32'(dec_lines), 32'(exp_lines));
        chk("R4", 32'(phi1), 32'(exp_lines[0]));
        chk("R4", 32'(phi2), 32'(exp_lines[2]));
        chk("R5", 32'(phi1 & phi2), 32'h0);
        if (prev_phase) chk("R6", 32'(phi1 | phi2), 32'h0);
        prev_phase = phi1 | phi2;
    endtask

    initial begin
        int hi1;
        int hi2;
        @(negedge clk);
        step(1'b0, 1'b0, "R1");
        step(1'b0, 1'b1, "R9");
        // First phi1 right after reset release.
        step(1'b1, 1'b1, "R2");
        chk("R2", 32'(phi1), 32'h1);
        for (int c = 0; c < 11; c++) step(1'b1, 1'b1, "R3");
        // Reset while running overrides enable.
        step(1'b0, 1'b1, "R9");
        chk("R1", 32'(dec_lines), 32'h0);
        // Exhaustive sweep of 8-cycle enable patterns.
        for (int p = 0; p < 256; p++) begin
            step(1'b0, 1'b0, "R1");
            for (int k = 0; k < 8; k++) begin
                logic e_k;
                e_k = p[k];
                step(1'b1, e_k, e_k ? "R3" : "R8");
            end
        end
        // Long continuous run: one high cycle in four for each phase.
        step(1'b0, 1'b0, "R1");
        hi1 = 0;
        hi2 = 0;
        for (int c = 0; c < 400; c++) begin
            step(1'b1, 1'b1, "R7");
            hi1 += int'(phi1);
            hi2 += int'(phi2);
        end
        chk("R7", 32'(hi1), 32'd100);
        chk("R7", 32'(hi2), 32'd100);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule